// File: doc/BRIEF.md
# Vector Address Offset Generator

This block turns a single request into a full 128-bit vector of per-lane address offsets for gather-load and scatter-store accesses. A request names one of five sequence modes, a start offset, a buffer limit, a step code and an element-width code. One cycle later the block returns the packed lane offsets and the offset that would come after the last lane.

The five modes cover ring buffers walked upward or downward, plain upward or downward strides with no limit, and bit-reversed index order for FFT data shuffles. The returned follow-on offset is meant to be fed back as the start of the next request. This lets a loop sweep a circular buffer, or step through a bit-reversed index space, one vector at a time with no gaps or repeats.

Top module: `vofs_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `out_valid` is 0, `out_vec` is all zeros and `out_next` is 0.
- R2: A request sampled with `in_valid` high at a rising edge appears on `out_vec`/`out_next` with `out_valid` high after that same edge. When `in_valid` is low at an edge, `out_valid` goes low and `out_vec`/`out_next` keep their values.
- R3: `in_ewidth` selects the lane layout. Code 0 gives 16 lanes of 8 bits, code 1 gives 8 lanes of 16 bits, and codes 2 and 3 give 4 lanes of 32 bits. Lane i occupies bits [i*w +: w] of `out_vec`, and each offset is truncated to the lane width w.
- R4: `in_step` code 0, 1, 2 and 3 selects a step of 1, 2, 4 and 8.
- R5: Mode 0 (upward ring): lane 0 is the start. Each following value is the previous one plus the step, and is replaced by 0 when that sum equals `in_size`.
- R6: Mode 1 (downward ring): lane 0 is the start. Each following value is `in_size` minus the step when the previous value is 0, and otherwise is the previous value minus the step.
- R7: Mode 2 adds the step and mode 3 subtracts it, both modulo 2^32. `in_size` has no effect in these modes.
- R8: Mode 4 (bit-reverse): lane i is the low n bits of (start + i) in reversed order, shifted left by the step code. Here n is `in_nbits`, clamped to 32. `out_next` is (start + lane count) masked to the low n bits.
- R9: In modes 0 to 3, `out_next` equals the value that the mode's rule would give after the last lane. A request whose start is the previous `out_next` therefore continues the sequence.
- R10: Mode codes 5, 6 and 7 produce an all-zero `out_vec` and return the start unchanged on `out_next`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_mode | input | 3 | Sequence mode code (0 to 4, others reserved) |
| in_start | input | 32 | Start offset / running index |
| in_size | input | 32 | Ring limit for modes 0 and 1 |
| in_step | input | 2 | Step code (1 << code) |
| in_ewidth | input | 2 | Element width code |
| in_nbits | input | 6 | Bits reversed in mode 4 |
| out_valid | output | 1 | Result valid, one cycle after request |
| out_vec | output | 128 | Packed lane offsets |
| out_next | output | 32 | Offset following the last lane |

## Verification
The bench builds the block with its default 128-bit vector, so the 8-bit layout exercises the longest chain of 16 lanes and the deepest wrap logic. At that width, small ring sizes such as 6 force several wraps inside one vector, in both directions. Reversal widths from 0 up to the clamp at 32 bits, and every step code, can all be reached. Chaining two requests through `out_next` tests that one vector continues where the previous one stopped.

// File: rtl/vofs_pkg.sv
package vofs_pkg;

    localparam int OFS_W = 32;
    localparam int CNT_W = 6;

    typedef logic [OFS_W-1:0] ofs_t;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [2:0] {
        VM_RING_UP   = 3'd0,
        VM_RING_DOWN = 3'd1,
        VM_LIN_UP    = 3'd2,
        VM_LIN_DOWN  = 3'd3,
        VM_BITREV    = 3'd4,
        VM_RSV5      = 3'd5,
        VM_RSV6      = 3'd6,
        VM_RSV7      = 3'd7
    } vmode_e;

    typedef enum logic [1:0] {
        EW_8   = 2'd0,
        EW_16  = 2'd1,
        EW_32  = 2'd2,
        EW_32B = 2'd3
    } ewidth_e;

    typedef struct packed {
        vmode_e  mode;
        ofs_t    start;
        ofs_t    size;
        ofs_t    step;
        ewidth_e ew;
        cnt_t    nbits;
    } vreq_t;

    // One step of a sequence mode: value of the lane following cur
    function automatic ofs_t step_once(vmode_e m, ofs_t cur, ofs_t size, ofs_t step);
        ofs_t sum;
        sum = cur + step;
        case (m)
            VM_RING_UP:   step_once = (sum == size) ? '0 : sum;
            VM_RING_DOWN: step_once = (cur == '0) ? (size - step) : (cur - step);
            VM_LIN_UP:    step_once = sum;
            VM_LIN_DOWN:  step_once = cur - step;
            default:      step_once = cur;
        endcase
    endfunction

    function automatic int clamp_bits(cnt_t n);
        clamp_bits = (int'(n) > OFS_W) ? OFS_W : int'(n);
    endfunction

    // Reverse the low n bits of v, clear the rest
    function automatic ofs_t reverse_low(ofs_t v, cnt_t n);
        int nn;
        nn = clamp_bits(n);
        reverse_low = '0;
        for (int k = 0; k < OFS_W; k++) begin
            if (k < nn) reverse_low[k] = v[nn-1-k];
        end
    endfunction

    function automatic ofs_t low_mask(cnt_t n);
        int nn;
        nn = clamp_bits(n);
        low_mask = '0;
        for (int k = 0; k < OFS_W; k++) begin
            if (k < nn) low_mask[k] = 1'b1;
        end
    endfunction

    // log2 of lane width in bytes
    function automatic int ew_shift(ewidth_e ew);
        case (ew)
            EW_8:    ew_shift = 0;
            EW_16:   ew_shift = 1;
            default: ew_shift = 2;
        endcase
    endfunction

endpackage

// File: rtl/vofs_seq.sv
module vofs_seq
    import vofs_pkg::*;
#(
    parameter int LANES = 16
) (
    input  vmode_e mode,
    input  ofs_t   start,
    input  ofs_t   size,
    input  ofs_t   step,
    output ofs_t   chain [LANES+1]
);

    assign chain[0] = start;

    for (genvar i = 0; i < LANES; i++) begin : g_link
        assign chain[i+1] = step_once(mode, chain[i], size, step);
    end

endmodule

// File: rtl/vofs_brev.sv
module vofs_brev
    import vofs_pkg::*;
#(
    parameter int LANES = 16
) (
    input  ofs_t       start,
    input  cnt_t       nbits,
    input  logic [1:0] shift,
    output ofs_t       lanes [LANES]
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        ofs_t idx;
        assign idx      = start + ofs_t'(i);
        assign lanes[i] = reverse_low(idx, nbits) << shift;
    end

endmodule

// File: rtl/vofs_pack.sv
module vofs_pack
    import vofs_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  ewidth_e            ew,
    input  ofs_t               lanes [VEC_W/8],
    output logic [VEC_W-1:0]   vec
);

    localparam int N8  = VEC_W / 8;
    localparam int N16 = VEC_W / 16;
    localparam int N32 = VEC_W / 32;

    logic [VEC_W-1:0] v8, v16, v32;

    for (genvar i = 0; i < N8; i++) begin : g_b8
        assign v8[i*8 +: 8] = lanes[i][7:0];
    end
    for (genvar i = 0; i < N16; i++) begin : g_b16
        assign v16[i*16 +: 16] = lanes[i][15:0];
    end
    for (genvar i = 0; i < N32; i++) begin : g_b32
        assign v32[i*32 +: 32] = lanes[i][31:0];
    end

    always_comb begin
        case (ew)
            EW_8:    vec = v8;
            EW_16:   vec = v16;
            default: vec = v32;
        endcase
    end

endmodule

// File: rtl/vofs_top.sv
module vofs_top
    import vofs_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [2:0]       in_mode,
    input  logic [31:0]      in_start,
    input  logic [31:0]      in_size,
    input  logic [1:0]       in_step,
    input  logic [1:0]       in_ewidth,
    input  logic [5:0]       in_nbits,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_vec,
    output logic [31:0]      out_next
);

    localparam int MAX_LANES = VEC_W / 8;

    vreq_t req;
    assign req.mode  = vmode_e'(in_mode);
    assign req.start = in_start;
    assign req.size  = in_size;
    assign req.step  = ofs_t'(1) << in_step;
    assign req.ew    = ewidth_e'(in_ewidth);
    assign req.nbits = in_nbits;

    ofs_t seq_chain [MAX_LANES+1];
    ofs_t rev_lanes [MAX_LANES];
    ofs_t sel_lanes [MAX_LANES];
    ofs_t next_d;
    ofs_t lane_cnt;
    logic [VEC_W-1:0] vec_d;

    vofs_seq #(.LANES(MAX_LANES)) u_seq (
        .mode  (req.mode),
        .start (req.start),
        .size  (req.size),
        .step  (req.step),
        .chain (seq_chain)
    );

    vofs_brev #(.LANES(MAX_LANES)) u_brev (
        .start (req.start),
        .nbits (req.nbits),
        .shift (in_step),
        .lanes (rev_lanes)
    );

    assign lane_cnt = ofs_t'(MAX_LANES >> ew_shift(req.ew));

    always_comb begin
        ofs_t seq_next;
        case (req.ew)
            EW_8:    seq_next = seq_chain[MAX_LANES];
            EW_16:   seq_next = seq_chain[MAX_LANES/2];
            default: seq_next = seq_chain[MAX_LANES/4];
        endcase
        for (int i = 0; i < MAX_LANES; i++) begin
            case (req.mode)
                VM_RING_UP, VM_RING_DOWN,
                VM_LIN_UP, VM_LIN_DOWN: sel_lanes[i] = seq_chain[i];
                VM_BITREV:              sel_lanes[i] = rev_lanes[i];
                default:                sel_lanes[i] = '0;
            endcase
        end
        case (req.mode)
            VM_RING_UP, VM_RING_DOWN,
            VM_LIN_UP, VM_LIN_DOWN: next_d = seq_next;
            VM_BITREV:              next_d = (req.start + lane_cnt) & low_mask(req.nbits);
            default:                next_d = req.start;
        endcase
    end

    vofs_pack #(.VEC_W(VEC_W)) u_pack (
        .ew    (req.ew),
        .lanes (sel_lanes),
        .vec   (vec_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_vec   <= '0;
            out_next  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_vec  <= vec_d;
                out_next <= next_d;
            end
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_vec) && $stable(out_next))); // R2

    AST_RING_UP_BOUND: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == 3'd0 && in_start < in_size
         && ((in_start | in_size) & ((32'd1 << in_step) - 32'd1)) == 32'd0)
        |=> out_next < $past(in_size)); // R5

    AST_RING_DOWN_BOUND: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == 3'd1 && in_start < in_size
         && ((in_start | in_size) & ((32'd1 << in_step) - 32'd1)) == 32'd0)
        |=> out_next < $past(in_size)); // R6

    AST_BREV_NEXT_RANGE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == 3'd4 && in_nbits < 6'd32)
        |=> (out_next >> $past(in_nbits)) == 32'd0); // R8

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode >= 3'd5)
        |=> (out_vec == '0 && out_next == $past(in_start))); // R10

endmodule

// File: tb/vofs_top_tb.sv
module vofs_top_tb;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [2:0]   in_mode = '0;
    logic [31:0]  in_start = '0;
    logic [31:0]  in_size = '0;
    logic [1:0]   in_step = '0;
    logic [1:0]   in_ewidth = '0;
    logic [5:0]   in_nbits = '0;
    logic         out_valid;
    logic [127:0] out_vec;
    logic [31:0]  out_next;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    vofs_top u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
        .in_start(in_start), .in_size(in_size), .in_step(in_step),
        .in_ewidth(in_ewidth), .in_nbits(in_nbits), .out_valid(out_valid),
        .out_vec(out_vec), .out_next(out_next)
    );

    // Reference sequence built from the requirement text
    function automatic void model(input int m, input logic [31:0] st, input logic [31:0] sz,
                                  input int sc, input int ec, input int nb,
                                  output logic [127:0] v, output logic [31:0] nx);
        int w, n, nn;
        logic [31:0] stp, cur, lane, idx, msk;
        w   = (ec == 0) ? 8 : (ec == 1) ? 16 : 32;
        n   = 128 / w;
        nn  = (nb > 32) ? 32 : nb;
        stp = 32'd1 << sc;
        cur = st;
        msk = (nn == 32) ? 32'hFFFF_FFFF : ((32'd1 << nn) - 32'd1);
        v   = '0;
        for (int i = 0; i < n; i++) begin
            lane = 32'd0;
            if (m <= 3) begin
                lane = cur;
                if (m == 0)      cur = (cur + stp == sz) ? 32'd0 : cur + stp;
                else if (m == 1) cur = (cur == 32'd0) ? sz - stp : cur - stp;
                else if (m == 2) cur = cur + stp;
                else             cur = cur - stp;
            end else if (m == 4) begin
                idx = st + 32'(i);
                for (int k = 0; k < nn; k++) lane[k] = idx[nn-1-k];
                lane = lane << sc;
            end
            for (int b = 0; b < w; b++) v[i*w + b] = lane[b];
        end
        if (m <= 3)      nx = cur;
        else if (m == 4) nx = (st + 32'(n)) & msk;
        else             nx = st;
    endfunction

    task automatic check_vec(string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s vec act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic check_word(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s word act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic issue(int m, logic [31:0] st, logic [31:0] sz, int sc, int ec, int nb);
        @(negedge clk);
        in_valid  = 1'b1;
        in_mode   = 3'(m);
        in_start  = st;
        in_size   = sz;
        in_step   = 2'(sc);
        in_ewidth = 2'(ec);
        in_nbits  = 6'(nb);
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    task automatic run_model(string tag, int m, logic [31:0] st, logic [31:0] sz,
                             int sc, int ec, int nb);
        logic [127:0] ev;
        logic [31:0]  en;
        model(m, st, sz, sc, ec, nb, ev, en);
        issue(m, st, sz, sc, ec, nb);
        check_word({tag, " valid"}, {31'd0, out_valid}, 32'd1);
        check_vec(tag, out_vec, ev);
        check_word({tag, " next"}, out_next, en);
    endtask

    task automatic t_reset();
        check_word("R1 valid", {31'd0, out_valid}, 32'd0);
        check_vec("R1 vec", out_vec, '0);
        check_word("R1 next", out_next, 32'd0);
    endtask

    task automatic t_ring_up();
        // R5: 16 lanes of 8 bits, size 6: 0..5,0..5,0..3, next 4
        issue(0, 32'd0, 32'd6, 0, 0, 0);
        check_vec("R5 literal", out_vec, 128'h03020100_05040302_01000504_03020100);
        check_word("R5 next", out_next, 32'd4);
        run_model("R5 step4 16b", 0, 32'd8, 32'd24, 2, 1, 0);
        run_model("R4 step8 8b", 0, 32'd0, 32'd40, 3, 0, 0);
    endtask

    task automatic t_ring_down();
        // R6: 4 lanes of 32 bits from 2, size 6: 2,1,0,5 next 4
        issue(1, 32'd2, 32'd6, 0, 2, 0);
        check_vec("R6 literal", out_vec, {32'd5, 32'd0, 32'd1, 32'd2});
        check_word("R6 next", out_next, 32'd4);
        run_model("R6 step2 8b", 1, 32'd4, 32'd10, 1, 0, 0);
    endtask

    task automatic t_linear();
        run_model("R7 up ignores size", 2, 32'hFFFF_FFF0, 32'd3, 2, 2, 0);
        run_model("R7 down 16b", 3, 32'd5, 32'd7, 0, 1, 0);
        run_model("R3 truncation 8b", 2, 32'd250, 32'd0, 0, 0, 0);
        run_model("R3 code3 as 32b", 2, 32'd100, 32'd0, 1, 3, 0);
    endtask

    task automatic t_bitrev();
        // R8: 3 bits, 16-bit lanes, step code 1 -> 0,8,4,12,2,10,6,14, next 0
        issue(4, 32'd0, 32'd0, 1, 1, 3);
        check_vec("R8 literal", out_vec,
                  {16'd14, 16'd6, 16'd10, 16'd2, 16'd12, 16'd4, 16'd8, 16'd0});
        check_word("R8 next", out_next, 32'd0);
        run_model("R8 5 bits 8b", 4, 32'd3, 32'd0, 0, 0, 5);
        run_model("R8 zero bits", 4, 32'd9, 32'd0, 2, 2, 0);
        run_model("R8 clamp 40", 4, 32'h1234_5678, 32'd0, 0, 2, 40);
    endtask

    task automatic t_chain();
        logic [31:0] nx;
        logic [127:0] ev;
        logic [31:0] en;
        // R9: two 32-bit vectors of an upward ring of 5 continue 0,1,2,3 | 4,0,1,2
        issue(0, 32'd0, 32'd5, 0, 2, 0);
        nx = out_next;
        check_word("R9 first next", nx, 32'd4);
        issue(0, nx, 32'd5, 0, 2, 0);
        check_vec("R9 continued", out_vec, {32'd2, 32'd1, 32'd0, 32'd4});
        model(1, 32'd3, 32'd8, 0, 2, 0, ev, en);
        issue(1, 32'd3, 32'd8, 0, 2, 0);
        check_word("R9 down next", out_next, en);
    endtask

    task automatic t_hold();
        logic [127:0] v0;
        logic [31:0]  n0;
        issue(2, 32'd7, 32'd0, 0, 0, 0);
        v0 = out_vec;
        n0 = out_next;
        @(negedge clk);
        in_start = 32'd999;
        in_mode  = 3'd3;
        @(negedge clk);
        check_word("R2 idle valid", {31'd0, out_valid}, 32'd0);
        check_vec("R2 hold vec", out_vec, v0);
        check_word("R2 hold next", out_next, n0);
    endtask

    task automatic t_reserved();
        run_model("R10 mode5", 5, 32'd77, 32'd9, 1, 0, 4);
        run_model("R10 mode7", 7, 32'hABCD, 32'd9, 3, 2, 4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ring_up();
        t_ring_down();
        t_linear();
        t_bitrev();
        t_chain();
        t_hold();
        t_reserved();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule